// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block decodes the bus write cycles presented to a 512K x 8 NOR flash array model and turns them into operations. Each write arrives as one clock-wide strobe with an address and a data byte already latched. Multi-cycle unlock sequences select one of four operations: identifier reads, single-byte programming, single-sector erase, and suspending and resuming an erase. The block tells the read path which source to return, through a read-source select together with the identifier and status bytes it computes. It also starts a small countdown engine that stands in for the embedded program and erase algorithms.

The array has eight uniform 64K-byte sectors, and the top three address bits pick the sector. Unlock cycles compare only the low 11 address bits. A suspended erase keeps its remaining count frozen. While an erase is suspended, reads inside the suspended sector return status and reads elsewhere return the array. An engine fault puts the block into an error state that only the reset command clears.

Top module: `nor_cmd_ctrl`

## Requirements
- R1: After the asynchronous reset, reads select the array (rd_sel = 0), busy is 0, and no command is needed to read.
- R2: The writes AAh@555h, 55h@2AAh, 90h@555h enter identifier mode (rd_sel = 1). In this mode id_data is 01h when rd_addr[1:0] = 00, A4h when it is 01, 00h when it is 11, and when it is 10 the protect bit prot_map[rd_addr[18:16]] (01h if protected, 00h if not).
- R3: Identifier mode ignores every write except F0h at any address. F0h returns to the mode the sequence started from: array read, or erase-suspend if entered there.
- R4: The writes AAh@555h, 55h@2AAh, A0h@555h, then a data write to any address, start a program. prog_start pulses for one cycle with tgt_addr and tgt_data holding the final write. busy stays high for exactly PROG_CYCLES+1 cycles. Only the low 11 address bits are compared on unlock cycles.
- R5: A write with a wrong address or data value, or one out of order, abandons the sequence. No start strobe follows, and reads stay in the base mode.
- R6: F0h written at any address between the cycles of a program, erase or identifier sequence abandons it. F0h written as the program data cycle is taken as data.
- R7: While a program or erase is running, reads return status (rd_sel = 2) with bit 7 = 0. F0h and all other writes are ignored, except B0h during an erase.
- R8: The writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, then 30h at any address in a sector, erase that sector. erase_start pulses once with tgt_addr[18:16] = the sector. busy stays high for exactly ERASE_CYCLES+1 cycles, counting only cycles not suspended.
- R9: B0h during an erase suspends it, and busy drops after the accepting edge. Reads inside the suspended sector then return status 84h (bit 7 ready, bit 2 suspended), and reads elsewhere return the array.
- R10: While suspended, the erase count is frozen. A write of 30h outside any sequence resumes the erase, and the erase completes with its remaining count.
- R11: While suspended, program and identifier sequences are accepted and erase setup (80h) is refused. A program in this state shows status 04h everywhere, and afterwards the suspended-sector read rule applies again.
- R12: op_fault high while the running engine counts ends the operation in an error state. In this state every read returns status A0h (bit 5 error, bit 7 ready) and only F0h leaves it. Leaving returns to array read and drops any suspended erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | One-cycle strobe of a latched bus write |
| wr_addr | input | 19 | Address of the bus write |
| wr_data | input | 8 | Data of the bus write |
| rd_addr | input | 19 | Current read address |
| prot_map | input | 8 | Protect flag per sector |
| op_fault | input | 1 | Engine error indication, taken while the engine counts |
| rd_sel | output | 2 | Read source: 0 array, 1 identifier, 2 status |
| id_data | output | 8 | Identifier byte for rd_addr |
| status_data | output | 8 | Status byte: bit 7 ready, bit 5 error, bit 2 erase suspended |
| busy | output | 1 | Program or erase in progress |
| prog_start | output | 1 | One-cycle program start strobe |
| erase_start | output | 1 | One-cycle erase start strobe |
| tgt_addr | output | 19 | Target address of the last started operation |
| tgt_data | output | 8 | Program data of the last started program |

## Verification
The bench builds the block with PROG_CYCLES = 3 and ERASE_CYCLES = 10, so each operation's busy window can be counted to the exact cycle. With a program that short, a whole program fits inside a suspended erase, and the bench can show that the erase count stays frozen across it. An erase of ten cycles leaves room to suspend right after it starts. It also leaves room to check that the busy cycles before the suspend and after the resume add up to the full count.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    localparam logic [7:0] CMD_UNLK1  = 8'hAA;
    localparam logic [7:0] CMD_UNLK2  = 8'h55;
    localparam logic [7:0] CMD_IDENT  = 8'h90;
    localparam logic [7:0] CMD_PROG   = 8'hA0;
    localparam logic [7:0] CMD_ESETUP = 8'h80;
    localparam logic [7:0] CMD_RST    = 8'hF0;
    localparam logic [7:0] CMD_SUSP   = 8'hB0;
    localparam logic [7:0] CMD_ERASE  = 8'h30;

    localparam int         UNL_W      = 11;
    localparam logic [UNL_W-1:0] ADR_UNLK1 = 11'h555;
    localparam logic [UNL_W-1:0] ADR_UNLK2 = 11'h2AA;

    localparam logic [7:0] ID_MAKER   = 8'h01;
    localparam logic [7:0] ID_PART    = 8'hA4;

    localparam int ST_READY = 7;
    localparam int ST_ERROR = 5;
    localparam int ST_SUSP  = 2;

    typedef enum logic [2:0] {
        MD_READ  = 3'd0,
        MD_IDENT = 3'd1,
        MD_PROG  = 3'd2,
        MD_ERASE = 3'd3,
        MD_SUSP  = 3'd4,
        MD_ERR   = 3'd5
    } mode_e;

    typedef enum logic [2:0] {
        SQ_IDLE = 3'd0,
        SQ_U1   = 3'd1,
        SQ_U2   = 3'd2,
        SQ_PD   = 3'd3,
        SQ_E0   = 3'd4,
        SQ_E1   = 3'd5,
        SQ_E2   = 3'd6
    } seq_e;

    typedef enum logic [1:0] {
        RS_ARRAY  = 2'd0,
        RS_IDENT  = 2'd1,
        RS_STATUS = 2'd2
    } rsel_e;

endpackage

// File: rtl/nor_op_timer.sv
module nor_op_timer #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic pause,
    input  logic clr,
    input  logic fault,
    output logic done,
    output logic fail
);
    localparam int CNT_W = $clog2(CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(CYCLES);
    localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

    typedef struct packed {
        logic             run;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    always_comb begin
        t_d = t_q;
        if (clr) begin
            t_d = '0;
        end else if (start) begin
            t_d.run = 1'b1;
            t_d.cnt = LOAD;
        end else if (t_q.run && !pause) begin
            if (fault || t_q.cnt == ONE) begin
                t_d = '0;
            end else begin
                t_d.cnt = t_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign done = t_q.run && !pause && !fault && (t_q.cnt == ONE);
    assign fail = t_q.run && !pause && fault;

    // R10: a paused count stays frozen
    a_r10_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (t_q.run && pause && !start && !clr) |=> (t_q.run && $stable(t_q.cnt)));

    // R4: a completion is a single pulse
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> !done);

endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int SECT_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              p_done,
    input  logic              p_fail,
    input  logic              e_done,
    input  logic              e_fail,
    output mode_e             mode,
    output logic              erase_susp,
    output logic [SECT_W-1:0] esec,
    output logic [ADDR_W-1:0] tgt_addr,
    output logic [7:0]        tgt_data,
    output logic              prog_start,
    output logic              erase_start
);
    typedef struct packed {
        mode_e             mode;
        seq_e              seq;
        logic              from_susp;
        logic [SECT_W-1:0] esec;
        logic [ADDR_W-1:0] taddr;
        logic [7:0]        tdata;
        logic              pstart;
        logic              estart;
    } st_t;

    st_t s_d, s_q;

    logic hit1, hit2, is_rst;

    always_comb begin
        hit1   = (wr_addr[UNL_W-1:0] == ADR_UNLK1);
        hit2   = (wr_addr[UNL_W-1:0] == ADR_UNLK2);
        is_rst = wr_en && (wr_data == CMD_RST);

        s_d        = s_q;
        s_d.pstart = 1'b0;
        s_d.estart = 1'b0;

        case (s_q.mode)
            MD_READ, MD_SUSP: begin
                if (wr_en) begin
                    s_d.seq = SQ_IDLE;
                    if (!(wr_data == CMD_RST && s_q.seq != SQ_PD)) begin
                        case (s_q.seq)
                            SQ_IDLE: begin
                                if (hit1 && wr_data == CMD_UNLK1) begin
                                    s_d.seq = SQ_U1;
                                end else if (s_q.mode == MD_SUSP && wr_data == CMD_ERASE) begin
                                    s_d.mode = MD_ERASE;
                                end
                            end
                            SQ_U1: begin
                                if (hit2 && wr_data == CMD_UNLK2) s_d.seq = SQ_U2;
                            end
                            SQ_U2: begin
                                if (hit1) begin
                                    if (wr_data == CMD_IDENT) begin
                                        s_d.mode      = MD_IDENT;
                                        s_d.from_susp = (s_q.mode == MD_SUSP);
                                    end else if (wr_data == CMD_PROG) begin
                                        s_d.seq = SQ_PD;
                                    end else if (wr_data == CMD_ESETUP && s_q.mode == MD_READ) begin
                                        s_d.seq = SQ_E0;
                                    end
                                end
                            end
                            SQ_PD: begin
                                s_d.mode      = MD_PROG;
                                s_d.from_susp = (s_q.mode == MD_SUSP);
                                s_d.taddr     = wr_addr;
                                s_d.tdata     = wr_data;
                                s_d.pstart    = 1'b1;
                            end
                            SQ_E0: begin
                                if (hit1 && wr_data == CMD_UNLK1) s_d.seq = SQ_E1;
                            end
                            SQ_E1: begin
                                if (hit2 && wr_data == CMD_UNLK2) s_d.seq = SQ_E2;
                            end
                            SQ_E2: begin
                                if (wr_data == CMD_ERASE) begin
                                    s_d.mode   = MD_ERASE;
                                    s_d.taddr  = wr_addr;
                                    s_d.esec   = wr_addr[ADDR_W-1 -: SECT_W];
                                    s_d.estart = 1'b1;
                                end
                            end
                            default: s_d.seq = SQ_IDLE;
                        endcase
                    end
                end
            end
            MD_IDENT: begin
                if (is_rst) begin
                    s_d.mode      = s_q.from_susp ? MD_SUSP : MD_READ;
                    s_d.from_susp = 1'b0;
                end
            end
            MD_PROG: begin
                if (p_fail) begin
                    s_d.mode      = MD_ERR;
                    s_d.from_susp = 1'b0;
                end else if (p_done) begin
                    s_d.mode      = s_q.from_susp ? MD_SUSP : MD_READ;
                    s_d.from_susp = 1'b0;
                end
            end
            MD_ERASE: begin
                if (e_fail) begin
                    s_d.mode = MD_ERR;
                end else if (e_done) begin
                    s_d.mode = MD_READ;
                end else if (wr_en && wr_data == CMD_SUSP) begin
                    s_d.mode = MD_SUSP;
                end
            end
            MD_ERR: begin
                if (is_rst) s_d.mode = MD_READ;
            end
            default: begin
                s_d.mode = MD_READ;
                s_d.seq  = SQ_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.mode <= MD_READ;
            s_q.seq  <= SQ_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign mode        = s_q.mode;
    assign esec        = s_q.esec;
    assign tgt_addr    = s_q.taddr;
    assign tgt_data    = s_q.tdata;
    assign prog_start  = s_q.pstart;
    assign erase_start = s_q.estart;
    assign erase_susp  = (s_q.mode == MD_SUSP) ||
                         (s_q.from_susp && (s_q.mode == MD_IDENT || s_q.mode == MD_PROG));

    // R3: identifier mode holds until a reset command
    a_r3_ident_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MD_IDENT && !(wr_en && wr_data == CMD_RST)) |=> (s_q.mode == MD_IDENT));

    // R7: a running program ignores the reset command
    a_r7_prog_ignores_rst: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MD_PROG && wr_en && wr_data == CMD_RST && !p_done && !p_fail)
        |=> (s_q.mode == MD_PROG));

    // R12: error state holds until a reset command
    a_r12_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.mode == MD_ERR && !(wr_en && wr_data == CMD_RST)) |=> (s_q.mode == MD_ERR));

    // R4: a start strobe is followed by the busy mode
    a_r4_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> (s_q.mode == MD_PROG));

    // R8: at most one start strobe at a time
    a_r8_start_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(prog_start && erase_start));

endmodule

// File: rtl/nor_read_sel.sv
module nor_read_sel
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int SECT_W = 3
) (
    input  mode_e             mode,
    input  logic              erase_susp,
    input  logic [SECT_W-1:0] esec,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [(1<<SECT_W)-1:0] prot_map,
    output logic [1:0]        rd_sel,
    output logic [7:0]        id_data,
    output logic [7:0]        status_data
);
    logic [SECT_W-1:0] rsec;
    logic              unused_mid;

    assign rsec       = rd_addr[ADDR_W-1 -: SECT_W];
    assign unused_mid = ^rd_addr[ADDR_W-SECT_W-1:2];

    always_comb begin
        case (mode)
            MD_READ:           rd_sel = RS_ARRAY;
            MD_IDENT:          rd_sel = RS_IDENT;
            MD_SUSP:           rd_sel = (rsec == esec) ? RS_STATUS : RS_ARRAY;
            default:           rd_sel = RS_STATUS;
        endcase
    end

    always_comb begin
        case (rd_addr[1:0])
            2'b00:   id_data = ID_MAKER;
            2'b01:   id_data = ID_PART;
            2'b10:   id_data = {7'd0, prot_map[rsec]};
            default: id_data = 8'h00;
        endcase
    end

    always_comb begin
        status_data           = 8'h00;
        status_data[ST_READY] = !(mode == MD_PROG || mode == MD_ERASE);
        status_data[ST_ERROR] = (mode == MD_ERR);
        status_data[ST_SUSP]  = erase_susp;
    end

endmodule

// File: rtl/nor_cmd_ctrl.sv
module nor_cmd_ctrl
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W       = 19,
    parameter int SECT_W       = 3,
    parameter int PROG_CYCLES  = 4,
    parameter int ERASE_CYCLES = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [7:0]             wr_data,
    input  logic [ADDR_W-1:0]      rd_addr,
    input  logic [(1<<SECT_W)-1:0] prot_map,
    input  logic                   op_fault,
    output logic [1:0]             rd_sel,
    output logic [7:0]             id_data,
    output logic [7:0]             status_data,
    output logic                   busy,
    output logic                   prog_start,
    output logic                   erase_start,
    output logic [ADDR_W-1:0]      tgt_addr,
    output logic [7:0]             tgt_data
);
    localparam int N_ENG = 2;

    mode_e             mode;
    logic              erase_susp;
    logic [SECT_W-1:0] esec;
    logic [N_ENG-1:0]  t_start, t_pause, t_clr, t_done, t_fail;

    nor_seq_fsm #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .p_done      (t_done[0]),
        .p_fail      (t_fail[0]),
        .e_done      (t_done[1]),
        .e_fail      (t_fail[1]),
        .mode        (mode),
        .erase_susp  (erase_susp),
        .esec        (esec),
        .tgt_addr    (tgt_addr),
        .tgt_data    (tgt_data),
        .prog_start  (prog_start),
        .erase_start (erase_start)
    );

    assign t_start = {erase_start, prog_start};
    assign t_pause = {(mode != MD_ERASE), 1'b0};
    assign t_clr   = {(mode == MD_ERR), 1'b0};

    for (genvar g = 0; g < N_ENG; g++) begin : g_eng
        localparam int CYC = (g == 0) ? PROG_CYCLES : ERASE_CYCLES;
        nor_op_timer #(.CYCLES(CYC)) u_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .start (t_start[g]),
            .pause (t_pause[g]),
            .clr   (t_clr[g]),
            .fault (op_fault),
            .done  (t_done[g]),
            .fail  (t_fail[g])
        );
    end

    nor_read_sel #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_rd (
        .mode        (mode),
        .erase_susp  (erase_susp),
        .esec        (esec),
        .rd_addr     (rd_addr),
        .prot_map    (prot_map),
        .rd_sel      (rd_sel),
        .id_data     (id_data),
        .status_data (status_data)
    );

    assign busy = (mode == MD_PROG) || (mode == MD_ERASE);

    // R2: identifier reads appear only in identifier mode
    a_r2_ident_only: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == RS_IDENT) |-> (mode == MD_IDENT));

    // R9: outside the suspended sector a suspended erase reads the array
    a_r9_susp_other_array: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MD_SUSP && rd_addr[ADDR_W-1 -: SECT_W] != esec) |-> (rd_sel == RS_ARRAY));

    // R7: while busy the ready bit is clear
    a_r7_busy_status: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (rd_sel == RS_STATUS && !status_data[ST_READY]));

endmodule

// File: tb/tb_nor_cmd_ctrl.sv
module tb_nor_cmd_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int PROG_N     = 3;
    localparam int ERASE_N    = 10;
    localparam logic [18:0] A1 = 19'h00555;
    localparam logic [18:0] A2 = 19'h002AA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [18:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [18:0] rd_addr = '0;
    logic [7:0]  prot_map = 8'b0010_0100;
    logic        op_fault = 1'b0;
    logic [1:0]  rd_sel;
    logic [7:0]  id_data, status_data, tgt_data;
    logic        busy, prog_start, erase_start;
    logic [18:0] tgt_addr;

    int checks = 0, fails = 0, bcnt = 0;
    int push_n = 0, done_n = 0;
    bit finished = 1'b0;

    typedef struct {
        string       tag;
        logic [18:0] addr;
        logic [1:0]  sel;
        logic [7:0]  val;
    } rd_exp_t;
    rd_exp_t sb[$];

    nor_cmd_ctrl #(.PROG_CYCLES(PROG_N), .ERASE_CYCLES(ERASE_N)) dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .prot_map(prot_map), .op_fault(op_fault),
        .rd_sel(rd_sel), .id_data(id_data), .status_data(status_data), .busy(busy),
        .prog_start(prog_start), .erase_start(erase_start),
        .tgt_addr(tgt_addr), .tgt_data(tgt_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        #2;
        if (busy) bcnt++;
    end

    // monitor: pops expected reads and compares against the outputs
    initial begin
        forever begin
            rd_exp_t it;
            logic [7:0] act;
            wait (push_n != done_n);
            it = sb.pop_front();
            rd_addr = it.addr;
            #1;
            checks++;
            act = (it.sel == 2'd1) ? id_data : (it.sel == 2'd2) ? status_data : 8'h00;
            if (rd_sel !== it.sel || (it.sel != 2'd0 && act !== it.val)) begin
                fails++;
                $display("FAIL %s addr=%h sel=%0d/%h expected sel=%0d/%h",
                         it.tag, it.addr, rd_sel, act, it.sel, it.val);
            end
            done_n++;
        end
    end

    task automatic exp_rd(input string tag, input logic [18:0] a,
                          input logic [1:0] sel, input logic [7:0] val);
        rd_exp_t it;
        it.tag = tag; it.addr = a; it.sel = sel; it.val = val;
        sb.push_back(it);
        push_n++;
        wait (done_n == push_n);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [18:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(A1, 8'hAA);
        wr(A2, 8'h55);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int c0, c1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        chk("R1 busy", busy, 0);
        exp_rd("R1", 19'h00000, 2'd0, 8'h00);
        exp_rd("R1", 19'h41234, 2'd0, 8'h00);

        // R2: identifier codes
        unlock(); wr(A1, 8'h90);
        exp_rd("R2 maker", 19'h00000, 2'd1, 8'h01);
        exp_rd("R2 part", 19'h00001, 2'd1, 8'hA4);
        exp_rd("R2 prot", 19'h50002, 2'd1, 8'h01);
        exp_rd("R2 unprot", 19'h10002, 2'd1, 8'h00);
        exp_rd("R2 other", 19'h00003, 2'd1, 8'h00);
        // R3: only F0 leaves
        wr(A1, 8'hAA); wr(19'h12345, 8'h00);
        exp_rd("R3 stay", 19'h00001, 2'd1, 8'hA4);
        wr(19'h7FFFF, 8'hF0);
        exp_rd("R3 exit", 19'h00001, 2'd0, 8'h00);

        // R4: program
        bcnt = 0;
        unlock(); wr(A1, 8'hA0); wr(19'h31234, 8'h5A);
        chk("R4 prog_start", prog_start, 1);
        chk("R4 tgt_addr", tgt_addr, 19'h31234);
        chk("R4 tgt_data", tgt_data, 8'h5A);
        exp_rd("R7 busy status", 19'h00000, 2'd2, 8'h00);
        wait_idle();
        chk("R4 busy cycles", bcnt, PROG_N + 1);
        chk("R4 strobe gone", prog_start, 0);
        exp_rd("R4 done", 19'h31234, 2'd0, 8'h00);

        // R4: upper address bits ignored on unlock; R7: writes ignored while busy
        bcnt = 0;
        wr(19'h78555, 8'hAA); wr(19'h402AA, 8'h55); wr(19'h00555, 8'hA0); wr(19'h00010, 8'h11);
        chk("R4 upper bits", prog_start, 1);
        wr(19'h00000, 8'hF0);
        chk("R7 F0 ignored", busy, 1);
        wr(19'h00000, 8'hB0);
        wait_idle();
        chk("R7 busy cycles", bcnt, PROG_N + 1);
        exp_rd("R7 after", 19'h00010, 2'd0, 8'h00);

        // R5: wrong address, out of order, wrong data
        wr(A1, 8'hAA); wr(19'h00123, 8'h55); wr(A1, 8'hA0); wr(19'h00040, 8'h77);
        chk("R5 bad addr start", prog_start, 0);
        chk("R5 bad addr busy", busy, 0);
        wr(A2, 8'h55); wr(A1, 8'hA0); wr(19'h00040, 8'h77);
        chk("R5 order", prog_start, 0);
        unlock(); wr(A1, 8'h77); wr(A1, 8'hA0); wr(19'h00040, 8'h77);
        chk("R5 bad data", prog_start | busy, 0);
        exp_rd("R5 read", 19'h00040, 2'd0, 8'h00);

        // R6: reset between cycles
        unlock(); wr(19'h7FFFF, 8'hF0); wr(A1, 8'hA0); wr(19'h00040, 8'h66);
        chk("R6 prog abort", prog_start | busy, 0);
        unlock(); wr(A1, 8'h80); wr(A1, 8'hAA); wr(19'h60000, 8'hF0); wr(A2, 8'h55); wr(19'h60000, 8'h30);
        chk("R6 erase abort", erase_start | busy, 0);
        unlock(); wr(A1, 8'hA0); wr(19'h20000, 8'hF0);
        chk("R6 F0 as data", prog_start, 1);
        chk("R6 F0 data", tgt_data, 8'hF0);
        wait_idle();

        // R8: sector erase
        bcnt = 0;
        unlock(); wr(A1, 8'h80); unlock(); wr(19'h54321, 8'h30);
        chk("R8 erase_start", erase_start, 1);
        chk("R8 sector", tgt_addr[18:16], 3'd5);
        exp_rd("R8 busy", 19'h00000, 2'd2, 8'h00);
        wait_idle();
        chk("R8 busy cycles", bcnt, ERASE_N + 1);
        exp_rd("R8 done", 19'h50000, 2'd0, 8'h00);

        // R9: suspend
        bcnt = 0;
        unlock(); wr(A1, 8'h80); unlock(); wr(19'h20100, 8'h30);
        wr(19'h00000, 8'hB0);
        chk("R9 busy drop", busy, 0);
        exp_rd("R9 in sector", 19'h20055, 2'd2, 8'h84);
        exp_rd("R9 other", 19'h30000, 2'd0, 8'h00);
        c0 = bcnt;
        repeat (4) @(negedge clk);
        chk("R10 frozen", bcnt, c0);

        // R11: program and identifier inside suspend, erase refused
        unlock(); wr(A1, 8'hA0); wr(19'h40001, 8'hC3);
        chk("R11 prog_start", prog_start, 1);
        exp_rd("R11 prog status", 19'h20000, 2'd2, 8'h04);
        c1 = bcnt;
        wait_idle();
        chk("R11 prog cycles", bcnt - c1, PROG_N + 1);
        exp_rd("R11 rule holds", 19'h20000, 2'd2, 8'h84);
        exp_rd("R11 other", 19'h40001, 2'd0, 8'h00);
        unlock(); wr(A1, 8'h90);
        exp_rd("R11 ident", 19'h20002, 2'd1, 8'h01);
        exp_rd("R11 ident maker", 19'h00000, 2'd1, 8'h01);
        wr(19'h00000, 8'hF0);
        exp_rd("R3 back to suspend", 19'h20000, 2'd2, 8'h84);
        unlock(); wr(A1, 8'h80); wr(A1, 8'hAA); wr(A2, 8'h55); wr(19'h10000, 8'h30);
        chk("R11 erase refused", erase_start | busy, 0);
        exp_rd("R11 still suspended", 19'h20000, 2'd2, 8'h84);

        // R10: resume completes remaining count
        c1 = bcnt;
        wr(19'h70000, 8'h30);
        chk("R10 resumed", busy, 1);
        chk("R10 no restart", erase_start, 0);
        wait_idle();
        chk("R10 total cycles", c0 + (bcnt - c1), ERASE_N + 1);
        exp_rd("R10 done", 19'h20000, 2'd0, 8'h00);

        // R12: fault during program
        unlock(); wr(A1, 8'hA0); wr(19'h10000, 8'hAB);
        op_fault = 1'b1;
        wait_idle();
        op_fault = 1'b0;
        exp_rd("R12 err", 19'h10000, 2'd2, 8'hA0);
        exp_rd("R12 err other", 19'h60000, 2'd2, 8'hA0);
        wr(A1, 8'hAA);
        exp_rd("R12 sticky", 19'h60000, 2'd2, 8'hA0);
        wr(19'h00012, 8'hF0);
        exp_rd("R12 exit", 19'h60000, 2'd0, 8'h00);

        // R12: fault in suspended program drops the suspended erase
        unlock(); wr(A1, 8'h80); unlock(); wr(19'h60000, 8'h30);
        wr(19'h00000, 8'hB0);
        unlock(); wr(A1, 8'hA0); wr(19'h00100, 8'h01);
        op_fault = 1'b1;
        wait_idle();
        op_fault = 1'b0;
        exp_rd("R12 susp err", 19'h60000, 2'd2, 8'hA0);
        wr(19'h00000, 8'hF0);
        exp_rd("R12 erase dropped", 19'h60000, 2'd0, 8'h00);
        wr(19'h00000, 8'h30);
        chk("R12 no resume", busy, 0);

        summary();
    end

endmodule